// File: doc/BRIEF.md
# Latched 16-bit interval timer

A down-counting interval timer with a pair of reload latches, reached from an 8-bit processor bus through four byte-wide register addresses. Software fills the low latch first and then writes the high byte of the counter; that single write completes the latch, moves the whole latch into the counter, starts the countdown and drops any pending timer flag. Writes to the low byte, and to the high latch address, touch only the latches, so a new reload value can be prepared while the counter keeps running.

The counter steps down once per clock. When it passes zero the block raises a sticky interrupt flag, which a read of the counter-low address clears. In continuous mode the counter reloads from the latch on every time-out and the flag is raised each period; in one-shot mode it wraps and keeps counting, raising the flag only once per load. An optional output pin gives either a single low pulse lasting from load to time-out or a square wave that flips at each time-out. A masked interrupt request is driven from the flag.

Top module: `ivt_timer`

## Requirements
- R1: Register address `addr` bit 0 picks the byte lane (0 low, 1 high) and bit 1 picks latch (1) or counter (0). A bus write to address 0 or 2 stores the byte in the low latch only; the counter keeps counting unchanged.
- R2: A bus write to address 1 stores the byte in the high latch and, at the same clock edge, loads the counter with {written byte, low latch}, restarts the countdown and clears the flag.
- R3: A bus write to address 3 stores the byte in the high latch only; no transfer into the counter occurs.
- R4: `rdata` shows counter low, counter high, low latch or high latch for addresses 0, 1, 2, 3. A bus read strobe at address 0 clears the flag; a read at any other address leaves it unchanged.
- R5: The counter decrements by one every clock. Loaded with N, it reads 0 N clocks after the load and times out on the next clock, when the flag is raised.
- R6: With `ctl_cont` = 1 the counter reloads from the latch at each time-out and the flag is raised every N+1 clocks.
- R7: With `ctl_cont` = 0 the counter wraps to all ones at time-out and the flag is raised only on the first time-out after a load.
- R8: With the pin enabled and `ctl_cont` = 0, `pin_out` goes low at a high-byte counter load and returns high at the following time-out, staying high afterwards.
- R9: With the pin enabled and `ctl_cont` = 1, `pin_out` goes low at a load and flips at every time-out.
- R10: With the pin disabled, `pin_out` is high.
- R11: `irq` is high exactly when the flag is set and the interrupt enable bit is 1; the flag holds its value independently of the enable.
- R12: Synchronous reset clears the flag, the interrupt enable, both mode bits, latches and counter, and leaves `pin_out` high.
- R13: A time-out and an address-0 read strobe in the same clock leave the flag set; a high-byte counter load in the same clock as a zero count wins: the counter takes the latch, the flag stays clear and the one-shot stays armed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sel | input | 1 | Bus access strobe for one clock |
| wr | input | 1 | 1 write, 0 read, qualified by `sel` |
| addr | input | 2 | Register address |
| wdata | input | BUS_W | Bus write data |
| rdata | output | BUS_W | Read data for `addr`, combinational |
| ctl_we | input | 1 | Loads the three mode bits below |
| ctl_cont | input | 1 | 1 continuous, 0 one-shot |
| ctl_pin_en | input | 1 | Enables the timer-driven pin |
| ctl_irq_en | input | 1 | Interrupt enable |
| flag | output | 1 | Sticky time-out flag |
| irq | output | 1 | Masked interrupt request |
| pin_out | output | 1 | Timer-driven output pin |

## Verification
Two pairs of functions can share one clock edge: the flag-raising time-out with the flag-clearing read of the counter-low address, and the time-out with a high-byte counter load. The bench counts clocks from a load so that the counter sits at zero, then places the read strobe, or a fresh high-byte write, on exactly the time-out edge. The first case is judged by the flag staying set; the second by the flag staying clear, the counter holding the new latch value and a later flag proving the one-shot remained armed.

// File: rtl/ivt_pkg.sv
`timescale 1ns/1ps
package ivt_pkg;
   // register address map: bit 0 = byte lane, bit 1 = latch side
   typedef enum logic [1:0] {
      REG_CNT_LO = 2'd0,
      REG_CNT_HI = 2'd1,
      REG_LAT_LO = 2'd2,
      REG_LAT_HI = 2'd3
   } reg_sel_e;

   typedef struct packed {
      logic pin_en;
      logic cont;
      logic irq_en;
   } ctl_t;

   localparam int LANES = 2;
endpackage

// File: rtl/ivt_regs.sv
`timescale 1ns/1ps
module ivt_regs #(
   parameter int BUS_W = 8,
   localparam int W = ivt_pkg::LANES * BUS_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sel,
   input  logic             wr,
   input  logic [1:0]       addr,
   input  logic [BUS_W-1:0] wdata,
   input  logic             ctl_we,
   input  logic             ctl_cont,
   input  logic             ctl_pin_en,
   input  logic             ctl_irq_en,
   output logic [W-1:0]     lat_q,
   output logic [W-1:0]     load_val,
   output ivt_pkg::ctl_t    ctl_q,
   output logic             load,
   output logic             rd_clr
);
   logic wr_s;
   assign wr_s   = sel & wr;
   assign load   = wr_s && (addr == ivt_pkg::REG_CNT_HI);
   assign rd_clr = sel && !wr && (addr == ivt_pkg::REG_CNT_LO);

   // one latch byte per lane; counter and latch addresses of a lane share it
   for (genvar g = 0; g < ivt_pkg::LANES; g++) begin : g_lane
      logic [BUS_W-1:0] q;
      always_ff @(posedge clk) begin
         if (rst)
            q <= '0;
         else if (wr_s && (addr[0] == 1'(g)))
            q <= wdata;
      end
      assign lat_q[g*BUS_W +: BUS_W] = q;
   end

   // value the counter takes on a high-byte load: new high byte, held low byte
   assign load_val = {wdata, lat_q[BUS_W-1:0]};

   always_ff @(posedge clk) begin
      if (rst)
         ctl_q <= '0;
      else if (ctl_we)
         ctl_q <= '{pin_en: ctl_pin_en, cont: ctl_cont, irq_en: ctl_irq_en};
   end

   // R3: a write to the high latch address never counts as a load
   assert_lathi_noload_R3: assert property (@(posedge clk) disable iff (rst)
      (sel && wr && addr == ivt_pkg::REG_LAT_HI) |-> !load);
endmodule

// File: rtl/ivt_counter.sv
`timescale 1ns/1ps
module ivt_counter #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic [W-1:0] lat_q,
   input  logic         cont,
   output logic [W-1:0] cnt_q,
   output logic         timeout
);
   localparam logic [W-1:0] ONE = W'(1);

   // a load on the zero cycle supersedes the time-out
   assign timeout = (cnt_q == '0) && !load;

   always_ff @(posedge clk) begin
      if (rst)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (timeout && cont)
         cnt_q <= lat_q;
      else
         cnt_q <= cnt_q - ONE;
   end

   assert_decrement_R5: assert property (@(posedge clk) disable iff (rst)
      (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

   assert_reload_R6: assert property (@(posedge clk) disable iff (rst)
      (timeout && cont) |=> (cnt_q == $past(lat_q)));

   assert_wrap_R7: assert property (@(posedge clk) disable iff (rst)
      (timeout && !cont) |=> (&cnt_q));
endmodule

// File: rtl/ivt_event.sv
`timescale 1ns/1ps
module ivt_event (
   input  logic clk,
   input  logic rst,
   input  logic load,
   input  logic timeout,
   input  logic rd_clr,
   input  logic cont,
   output logic flag_q,
   output logic pin_q
);
   logic armed_q;
   logic fire;

   assign fire = timeout && (cont || armed_q);

   always_ff @(posedge clk) begin
      if (rst) begin
         flag_q  <= 1'b0;
         armed_q <= 1'b0;
         pin_q   <= 1'b1;
      end else begin
         // flag: load clears, time-out sets, set beats the read clear
         if (load)
            flag_q <= 1'b0;
         else if (fire)
            flag_q <= 1'b1;
         else if (rd_clr)
            flag_q <= 1'b0;

         if (load)
            armed_q <= 1'b1;
         else if (timeout)
            armed_q <= 1'b0;

         if (load)
            pin_q <= 1'b0;
         else if (fire)
            pin_q <= cont ? ~pin_q : 1'b1;
      end
   end

   assert_load_clears_R2: assert property (@(posedge clk) disable iff (rst)
      load |=> !flag_q);

   assert_set_wins_R13: assert property (@(posedge clk) disable iff (rst)
      fire |=> flag_q);

   assert_rd_clear_R4: assert property (@(posedge clk) disable iff (rst)
      (rd_clr && !fire && !load) |=> !flag_q);

   assert_pin_low_R8: assert property (@(posedge clk) disable iff (rst)
      load |=> !pin_q);

   assert_oneshot_once_R7: assert property (@(posedge clk) disable iff (rst)
      (!cont && !armed_q && !load) |=> (flag_q == 1'b0 || $past(flag_q)));
endmodule

// File: rtl/ivt_timer.sv
`timescale 1ns/1ps
module ivt_timer #(
   parameter int BUS_W = 8,
   localparam int W = ivt_pkg::LANES * BUS_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             sel,
   input  logic             wr,
   input  logic [1:0]       addr,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] rdata,
   input  logic             ctl_we,
   input  logic             ctl_cont,
   input  logic             ctl_pin_en,
   input  logic             ctl_irq_en,
   output logic             flag,
   output logic             irq,
   output logic             pin_out
);
   if (BUS_W < 4 || BUS_W > 32) begin : g_bad_bus_w
      $error("ivt_timer: BUS_W must lie in 4..32");
   end

   logic [W-1:0]  lat_q;
   logic [W-1:0]  load_val;
   logic [W-1:0]  cnt_q;
   ivt_pkg::ctl_t ctl_q;
   logic          load;
   logic          rd_clr;
   logic          timeout;
   logic          pin_q;

   ivt_regs #(.BUS_W(BUS_W)) u_regs (
      .clk(clk), .rst(rst), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
      .ctl_we(ctl_we), .ctl_cont(ctl_cont), .ctl_pin_en(ctl_pin_en),
      .ctl_irq_en(ctl_irq_en), .lat_q(lat_q), .load_val(load_val),
      .ctl_q(ctl_q), .load(load), .rd_clr(rd_clr)
   );

   ivt_counter #(.W(W)) u_cnt (
      .clk(clk), .rst(rst), .load(load), .load_val(load_val), .lat_q(lat_q),
      .cont(ctl_q.cont), .cnt_q(cnt_q), .timeout(timeout)
   );

   ivt_event u_evt (
      .clk(clk), .rst(rst), .load(load), .timeout(timeout), .rd_clr(rd_clr),
      .cont(ctl_q.cont), .flag_q(flag), .pin_q(pin_q)
   );

   always_comb begin
      unique case (addr)
         ivt_pkg::REG_CNT_LO: rdata = cnt_q[BUS_W-1:0];
         ivt_pkg::REG_CNT_HI: rdata = cnt_q[W-1:BUS_W];
         ivt_pkg::REG_LAT_LO: rdata = lat_q[BUS_W-1:0];
         default:             rdata = lat_q[W-1:BUS_W];
      endcase
   end

   assign irq     = flag & ctl_q.irq_en;
   assign pin_out = ctl_q.pin_en ? pin_q : 1'b1;

   assert_hi_load_R2: assert property (@(posedge clk) disable iff (rst)
      (sel && wr && addr == ivt_pkg::REG_CNT_HI)
      |=> (cnt_q == {$past(wdata), $past(lat_q[BUS_W-1:0])}));

   assert_pin_idle_R10: assert property (@(posedge clk) disable iff (rst)
      !ctl_q.pin_en |-> pin_out);
endmodule

// File: tb/sim_ivt_timer.sv
`timescale 1ns/1ps
module sim_ivt_timer;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       sel = 1'b0;
   logic       wr = 1'b0;
   logic [1:0] addr = 2'd0;
   logic [7:0] wdata = 8'd0;
   logic [7:0] rdata;
   logic       ctl_we = 1'b0;
   logic       ctl_cont = 1'b0;
   logic       ctl_pin_en = 1'b0;
   logic       ctl_irq_en = 1'b0;
   logic       flag;
   logic       irq;
   logic       pin_out;

   int  n_chk = 0;
   int  n_bad = 0;
   bit  done = 1'b0;

   always #5 clk = ~clk;

   ivt_timer #(.BUS_W(8)) u0 (
      .clk(clk), .rst(rst), .sel(sel), .wr(wr), .addr(addr), .wdata(wdata),
      .rdata(rdata), .ctl_we(ctl_we), .ctl_cont(ctl_cont),
      .ctl_pin_en(ctl_pin_en), .ctl_irq_en(ctl_irq_en),
      .flag(flag), .irq(irq), .pin_out(pin_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
   endtask

   // every task starts at a negedge and ends at the negedge after one edge
   task automatic bwr(input logic [1:0] a, input logic [7:0] d);
      sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
      @(negedge clk);
      sel = 1'b0; wr = 1'b0;
   endtask

   task automatic brd(input logic [1:0] a, output logic [7:0] d);
      sel = 1'b1; wr = 1'b0; addr = a;
      #1 d = rdata;
      @(negedge clk);
      sel = 1'b0;
   endtask

   task automatic peek(input logic [1:0] a, output logic [7:0] d);
      addr = a;
      #1 d = rdata;
   endtask

   task automatic setctl(input logic c, input logic p, input logic ie);
      ctl_we = 1'b1; ctl_cont = c; ctl_pin_en = p; ctl_irq_en = ie;
      @(negedge clk);
      ctl_we = 1'b0;
   endtask

   task automatic waitn(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic t_reset();
      logic [7:0] d;
      check("R12 flag after reset", flag, 0);
      check("R12 irq after reset", irq, 0);
      check("R12 pin after reset", pin_out, 1);
      peek(2'd2, d); check("R12 low latch after reset", d, 8'h00);
      peek(2'd3, d); check("R12 high latch after reset", d, 8'h00);
   endtask

   task automatic t_registers();
      logic [7:0] d;
      bwr(2'd0, 8'h10);
      bwr(2'd1, 8'h00);
      peek(2'd0, d); check("R2 counter low after load", d, 8'h10);
      bwr(2'd2, 8'h55);
      peek(2'd0, d); check("R1 counter keeps counting", d, 8'h0F);
      peek(2'd1, d); check("R1 counter high untouched", d, 8'h00);
      peek(2'd2, d); check("R1 R4 low latch read", d, 8'h55);
      bwr(2'd3, 8'h77);
      peek(2'd1, d); check("R3 no transfer to counter", d, 8'h00);
      peek(2'd0, d); check("R3 counter low counting", d, 8'h0E);
      peek(2'd3, d); check("R3 R4 high latch read", d, 8'h77);
      bwr(2'd0, 8'h99);
      peek(2'd0, d); check("R1 counter-low write leaves counter", d, 8'h0D);
      peek(2'd2, d); check("R1 counter-low write hits latch", d, 8'h99);
      bwr(2'd1, 8'h01);
      peek(2'd0, d); check("R2 load low byte from latch", d, 8'h99);
      peek(2'd1, d); check("R2 load high byte from bus", d, 8'h01);
      peek(2'd3, d); check("R2 high latch written", d, 8'h01);
   endtask

   task automatic t_oneshot();
      logic [7:0] d;
      setctl(1'b0, 1'b0, 1'b1);
      bwr(2'd0, 8'd5);
      bwr(2'd1, 8'd0);
      check("R2 flag clear after load", flag, 0);
      waitn(5);
      peek(2'd0, d); check("R5 counter at zero", d, 8'h00);
      check("R5 no flag before time-out", flag, 0);
      waitn(1);
      check("R5 flag at time-out", flag, 1);
      check("R11 irq with enable", irq, 1);
      peek(2'd0, d); check("R7 wrap low", d, 8'hFF);
      peek(2'd1, d); check("R7 wrap high", d, 8'hFF);
      brd(2'd2, d);
      check("R4 latch read data", d, 8'd5);
      check("R4 latch read keeps flag", flag, 1);
      setctl(1'b0, 1'b0, 1'b0);
      check("R11 irq masked", irq, 0);
      check("R11 flag kept while masked", flag, 1);
      brd(2'd0, d);
      check("R4 counter-low read clears flag", flag, 0);
      waitn(65540);
      check("R7 no second flag after wrap", flag, 0);
   endtask

   task automatic t_continuous();
      logic [7:0] d;
      setctl(1'b1, 1'b0, 1'b0);
      bwr(2'd0, 8'd3);
      bwr(2'd1, 8'd0);
      waitn(4);
      check("R6 flag after N+1", flag, 1);
      peek(2'd0, d); check("R6 reload from latch", d, 8'd3);
      brd(2'd0, d);
      check("R4 read clears flag", flag, 0);
      waitn(2);
      check("R6 no flag mid period", flag, 0);
      waitn(1);
      check("R6 flag next period", flag, 1);
   endtask

   task automatic t_pin_oneshot();
      setctl(1'b0, 1'b1, 1'b0);
      bwr(2'd0, 8'd4);
      bwr(2'd1, 8'd0);
      check("R8 pin low at load", pin_out, 0);
      waitn(4);
      check("R8 pin low before time-out", pin_out, 0);
      waitn(1);
      check("R8 pin high at time-out", pin_out, 1);
      waitn(10);
      check("R8 pin stays high", pin_out, 1);
   endtask

   task automatic t_square();
      setctl(1'b1, 1'b1, 1'b0);
      bwr(2'd0, 8'd2);
      bwr(2'd1, 8'd0);
      check("R9 pin low at load", pin_out, 0);
      waitn(3);
      check("R9 first toggle", pin_out, 1);
      waitn(3);
      check("R9 second toggle", pin_out, 0);
      waitn(3);
      check("R9 third toggle", pin_out, 1);
   endtask

   task automatic t_pin_off();
      setctl(1'b1, 1'b0, 1'b0);
      for (int i = 0; i < 6; i++) begin
         check("R10 pin high when disabled", pin_out, 1);
         waitn(1);
      end
   endtask

   task automatic t_collide();
      logic [7:0] d;
      setctl(1'b1, 1'b0, 1'b0);
      bwr(2'd0, 8'd3);
      bwr(2'd1, 8'd0);
      waitn(3);
      check("R13 flag clear before edge", flag, 0);
      brd(2'd0, d);
      check("R13 read data at zero", d, 8'h00);
      check("R13 time-out beats read clear", flag, 1);
      setctl(1'b0, 1'b0, 1'b0);
      bwr(2'd1, 8'd0);
      waitn(3);
      bwr(2'd1, 8'd0);
      check("R13 load beats time-out flag", flag, 0);
      peek(2'd0, d); check("R13 load beats time-out count", d, 8'd3);
      waitn(3);
      check("R13 still armed, no flag yet", flag, 0);
      waitn(1);
      check("R13 armed one-shot fires", flag, 1);
   endtask

   task automatic t_reset_mid();
      setctl(1'b1, 1'b1, 1'b1);
      bwr(2'd0, 8'd1);
      bwr(2'd1, 8'd0);
      waitn(3);
      check("R12 flag set before reset", flag, 1);
      rst = 1'b1;
      waitn(1);
      rst = 1'b0;
      check("R12 flag cleared by reset", flag, 0);
      check("R12 irq cleared by reset", irq, 0);
      check("R12 pin high after reset", pin_out, 1);
      bwr(2'd0, 8'd2);
      bwr(2'd1, 8'd0);
      check("R12 pin control cleared", pin_out, 1);
      waitn(3);
      check("R12 flag still works", flag, 1);
      check("R12 enable cleared", irq, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         summary();
         $finish;
      end
   end

   initial begin
      waitn(3);
      rst = 1'b0;
      t_reset();
      t_registers();
      t_oneshot();
      t_continuous();
      t_pin_oneshot();
      t_square();
      t_pin_off();
      t_collide();
      t_reset_mid();
      done = 1'b1;
      summary();
      $finish;
   end
endmodule